// File: doc/BRIEF.md
# Twisted-Pair / Attachment-Unit Port Autoswitch

This controller decides which physical port a 10 Mb/s transceiver uses: the twisted-pair port or the attachment-unit port. It has two modes. In manual mode the port follows a select bit. In automatic mode the port follows the link state on the twisted pair. A lost link moves traffic to the attachment-unit port, and a returning link brings it back.

A port change never cuts a frame. Every change waits until both transmit and receive activity have stayed low for a programmable number of consecutive cycles. A move to the attachment-unit port also waits while the twisted-pair transmitter is jabbering, and for the unjab interval after it. A status output always reports the port that is in use. The surrounding logic supplies the activity, link and jabber flags. This block only makes the switching decision.

Top module: `port_autoswitch`

## Requirements
- R1: After reset both `portAui` and `statusAui` are 0. The value 0 means twisted pair and 1 means attachment unit.
- R2: While `autoEn` and `speed10` are both 1, `manualAui` has no effect on the port. The automatic choice starts at twisted pair (0) each time automatic mode becomes active.
- R3: In automatic mode, `linkFail`=1 selects the attachment unit. If `linkFail`=0 and `linkPulse`=1, twisted pair is selected. If both are 0, the previous automatic choice is kept. If both are 1, `linkFail` wins.
- R4: The port does not change in any cycle that follows a cycle with `txActive` or `rxActive` high. A change commits only after IDLE_CYCLES consecutive idle cycles, on the next clock edge that is still idle.
- R5: A pending change is dropped if the target returns to the current port before the frame boundary is reached.
- R6: A move to the attachment unit is held off while `jabber` is 1. After `jabber` falls, the move also waits for a one-cycle `unjabDone` pulse, and it commits no earlier than the edge after that pulse.
- R7: When `speed10` is 0, automatic mode is inactive and the port follows `manualAui`.
- R8: When `autoEn` is 0, the port follows `manualAui`, subject to the same frame-boundary deferral as R4.
- R9: `statusAui` always equals `portAui`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| autoEn | input | 1 | Automatic switching enable (control bit, reset value 0) |
| manualAui | input | 1 | Manual port choice, 1 = attachment unit |
| speed10 | input | 1 | 1 when operating at 10 Mb/s |
| linkPulse | input | 1 | Link pulses are being detected on twisted pair |
| linkFail | input | 1 | Twisted-pair link-fail state |
| txActive | input | 1 | A frame is being transmitted |
| rxActive | input | 1 | A frame is being received |
| jabber | input | 1 | Twisted-pair transmitter is jabbering |
| unjabDone | input | 1 | One-cycle pulse marking the end of the unjab interval |
| portAui | output | 1 | Active port select, 1 = attachment unit |
| statusAui | output | 1 | Status bit reporting the active port |

## Verification
The bench builds the block with IDLE_CYCLES set to 3 instead of the default 2. With that setting there is a window of several cycles in which the link has already changed but the frame boundary has not yet been reached. In that window the bench can show that the port holds for exactly three idle cycles and moves on the fourth. The same window lets the bench cancel a pending change and show that the port never moves. It also lets the bench separate the jabber hold from the unjab pulse, cycle by cycle.

// File: rtl/port_autoswitch_pkg.sv
package port_autoswitch_pkg;
  localparam logic PORT_TP  = 1'b0;
  localparam logic PORT_AUI = 1'b1;

  typedef struct packed {
    logic commit;
    logic toAui;
  } swStrobe_t;
endpackage

// File: rtl/port_autoswitch_path.sv
module port_autoswitch_path
  import port_autoswitch_pkg::*;
#(
  parameter int IDLE_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      txActive,
  input  logic      rxActive,
  input  logic      jabber,
  input  logic      unjabDone,
  input  swStrobe_t strobe,
  output logic      portAui,
  output logic      statusAui,
  output logic      frameQuiet,
  output logic      jabBlock
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYCLES);

  logic [CW-1:0] idleCnt;
  logic          jabHold;
  logic          portReg;
  logic          statusReg;
  logic          lineBusy;

  assign lineBusy = txActive | rxActive;

  // consecutive idle cycles, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (lineBusy) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign frameQuiet = (idleCnt == IDLE_MAX) && !lineBusy;

  // jabber holds until the unjab interval is reported over
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jabHold <= 1'b0;
    end else if (jabber) begin
      jabHold <= 1'b1;
    end else if (unjabDone) begin
      jabHold <= 1'b0;
    end
  end

  assign jabBlock = jabHold | jabber;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      portReg   <= PORT_TP;
      statusReg <= PORT_TP;
    end else if (strobe.commit) begin
      portReg   <= strobe.toAui;
      statusReg <= strobe.toAui;
    end
  end

  assign portAui   = portReg;
  assign statusAui = statusReg;

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lineBusy |=> $stable(portAui)); // R4
  AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (idleCnt != IDLE_MAX) |=> $stable(portAui)); // R4
  AST_JAB_NO_AUI: assert property (@(posedge clk) disable iff (!rst_n)
    (jabBlock && !portAui) |=> !portAui); // R6
endmodule

// File: rtl/port_autoswitch_ctrl.sv
module port_autoswitch_ctrl
  import port_autoswitch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      autoEn,
  input  logic      manualAui,
  input  logic      speed10,
  input  logic      linkPulse,
  input  logic      linkFail,
  input  logic      frameQuiet,
  input  logic      jabBlock,
  input  logic      portAui,
  output swStrobe_t strobe
);
  logic autoActive;
  logic autoTarget;
  logic targetAui;
  logic pending;
  logic blocked;

  assign autoActive = autoEn & speed10;

  // automatic choice: twisted pair on entry, fail wins over pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      autoTarget <= PORT_TP;
    end else if (!autoActive) begin
      autoTarget <= PORT_TP;
    end else if (linkFail) begin
      autoTarget <= PORT_AUI;
    end else if (linkPulse) begin
      autoTarget <= PORT_TP;
    end
  end

  assign targetAui = autoActive ? autoTarget : manualAui;
  assign pending   = (targetAui != portAui);
  assign blocked   = targetAui & jabBlock;

  always_comb begin
    strobe.commit = pending & frameQuiet & !blocked;
    strobe.toAui  = targetAui;
  end

  AST_AUTO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (autoActive && linkFail) |=> autoTarget); // R3
  AST_AUTO_IGNORES_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (autoActive && !autoTarget && !portAui) |=> !portAui); // R2
  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!autoActive && frameQuiet && !jabBlock && (manualAui != portAui))
      |=> (portAui == $past(manualAui))); // R8
endmodule

// File: rtl/port_autoswitch.sv
module port_autoswitch
  import port_autoswitch_pkg::*;
#(
  parameter int IDLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic autoEn,
  input  logic manualAui,
  input  logic speed10,
  input  logic linkPulse,
  input  logic linkFail,
  input  logic txActive,
  input  logic rxActive,
  input  logic jabber,
  input  logic unjabDone,
  output logic portAui,
  output logic statusAui
);
  swStrobe_t strobe;
  logic      frameQuiet;
  logic      jabBlock;

  port_autoswitch_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .autoEn     (autoEn),
    .manualAui  (manualAui),
    .speed10    (speed10),
    .linkPulse  (linkPulse),
    .linkFail   (linkFail),
    .frameQuiet (frameQuiet),
    .jabBlock   (jabBlock),
    .portAui    (portAui),
    .strobe     (strobe)
  );

  port_autoswitch_path #(.IDLE_CYCLES(IDLE_CYCLES)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .txActive   (txActive),
    .rxActive   (rxActive),
    .jabber     (jabber),
    .unjabDone  (unjabDone),
    .strobe     (strobe),
    .portAui    (portAui),
    .statusAui  (statusAui),
    .frameQuiet (frameQuiet),
    .jabBlock   (jabBlock)
  );

  AST_STATUS_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> (statusAui == $past(strobe.toAui))); // R9
endmodule

// File: tb/port_autoswitch_test.sv
module port_autoswitch_test;
  localparam int IDLE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic autoEn = 0, manualAui = 0, speed10 = 1, linkPulse = 0, linkFail = 0;
  logic txActive = 0, rxActive = 0, jabber = 0, unjabDone = 0;
  logic portAui, statusAui;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  port_autoswitch #(.IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .autoEn(autoEn), .manualAui(manualAui),
    .speed10(speed10), .linkPulse(linkPulse), .linkFail(linkFail),
    .txActive(txActive), .rxActive(rxActive), .jabber(jabber),
    .unjabDone(unjabDone), .portAui(portAui), .statusAui(statusAui)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectPort(input logic exp, input string req);
    checks++;
    if (portAui !== exp) begin
      errors++;
      $display("FAIL %s: portAui actual %b expected %b", req, portAui, exp);
    end
    checks++;
    if (statusAui !== portAui) begin
      errors++;
      $display("FAIL R9: statusAui actual %b expected %b", statusAui, portAui);
    end
  endtask

  task automatic testReset();
    rst_n = 0; tick(3); rst_n = 1; tick(1);
    expectPort(1'b0, "R1");
  endtask

  task automatic testManual();
    autoEn = 0; rxActive = 1; manualAui = 1;
    tick(5);  expectPort(1'b0, "R4 manual busy");
    rxActive = 0;
    tick(IDLE); expectPort(1'b0, "R4 settle");
    tick(1);  expectPort(1'b1, "R8 commit");
    manualAui = 0;
    tick(1);  expectPort(1'b0, "R8 back");
  endtask

  task automatic testAutoOverride();
    autoEn = 1; speed10 = 1; manualAui = 1; linkPulse = 1;
    tick(4);  expectPort(1'b0, "R2 manual ignored");
  endtask

  task automatic testMidFrameLoss();
    txActive = 1; tick(2);
    linkFail = 1; linkPulse = 0;
    tick(6);  expectPort(1'b0, "R4 mid-frame");
    txActive = 0;
    tick(IDLE); expectPort(1'b0, "R4 settle");
    tick(1);  expectPort(1'b1, "R3 to aui");
    linkFail = 0;
    tick(4);  expectPort(1'b1, "R3 hold");
    linkPulse = 1;
    tick(2);  expectPort(1'b0, "R3 back to tp");
  endtask

  task automatic testCancel();
    rxActive = 1;
    linkFail = 1; linkPulse = 0; tick(3);
    linkFail = 0; linkPulse = 1; tick(2);
    rxActive = 0;
    tick(8);  expectPort(1'b0, "R5 cancelled");
  endtask

  task automatic testPriority();
    linkFail = 1; linkPulse = 1;
    tick(2);  expectPort(1'b1, "R3 fail wins");
    linkFail = 0;
    tick(2);  expectPort(1'b0, "R3 pulse returns");
  endtask

  task automatic testJabber();
    jabber = 1; tick(1);
    linkFail = 1; linkPulse = 0;
    tick(6);  expectPort(1'b0, "R6 jabbering");
    jabber = 0;
    tick(4);  expectPort(1'b0, "R6 unjab wait");
    unjabDone = 1; tick(1); unjabDone = 0;
    expectPort(1'b0, "R6 pulse edge");
    tick(1);  expectPort(1'b1, "R6 after unjab");
    linkFail = 0; linkPulse = 1;
    tick(2);  expectPort(1'b0, "R3 restore");
  endtask

  task automatic testSpeed();
    speed10 = 0; manualAui = 1;
    tick(1);  expectPort(1'b1, "R7 manual at 100M");
    speed10 = 1;
    tick(1);  expectPort(1'b0, "R7 auto resumes tp");
    autoEn = 0;
    tick(1);  expectPort(1'b1, "R8 auto off");
  endtask

  initial begin
    testReset();
    testManual();
    testAutoOverride();
    testMidFrameLoss();
    testCancel();
    testPriority();
    testJabber();
    testSpeed();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule